// File: doc/BRIEF.md
# Counter-Addressed Shared SRAM Arbiter

This block lets one external single-port SRAM of 2M x 8 serve two independent agents as if it were dual-ported. The first agent only writes. It places an address on `wr_addr`, drives its own data onto the SRAM data bus when the block enables it, and pulses `wr_stb_a`. The second agent only reads, and it has no address bus. Its address comes from an internal 21-bit counter. That counter steps on each rising edge of a separate, free-running counter clock. On that same edge it can instead be loaded with a preset value, and a programmable offset is added to the count to form the actual read address.

Both the write strobe and the counter clock are asynchronous to the fast system clock. Each passes through a two-stage synchronizer followed by a rising-edge detector. Detected events become pending requests. A small sequencer serves these requests one at a time on the shared address and control pins. A write is served before a read when both are pending. The sequencer generates the write-enable timing and the output-enable access window. At the end of a read it captures the SRAM data into a holding register and pulses a latch strobe. The block never carries write data itself. It only tells the external buffer when to drive the bus.

Top module: `sram_share_arb`

## Requirements
- R1: After a synchronous reset, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, `wr_bus_en`, `rd_latch`, `rd_data` and `sram_addr` are 0, and the read counter holds 0, so the first counter step with a zero offset reads address 1.
- R2: A rising edge on `wr_stb_a` captures `wr_addr` once the edge has been synchronized (by the second system clock after the edge). Later changes of `wr_addr` have no effect on that write, which lands on the captured address.
- R3: A write drives its address with `sram_ce_n`=0 and `sram_we_n`=1 for one cycle. It then holds `sram_we_n`=0 for exactly WE_CYC (4) cycles, with the address stable and `wr_bus_en`=1. It then raises `sram_we_n` while keeping the address and `sram_ce_n`=0 for one more cycle. `sram_we_n` first reads 0 on the 5th clock after the strobe edge.
- R4: Each rising edge of `cnt_clk_a` with `cnt_load`=0 increments the read counter by one, modulo 2^21 (0x1FFFFF wraps to 0).
- R5: A rising edge of `cnt_clk_a` with `cnt_load`=1 loads `cnt_preload` into the counter instead of incrementing it.
- R6: The read address is (counter + `rd_offset`) modulo 2^21, taken from the counter value after that edge's step or load.
- R7: Each counter edge triggers one read. During the read, `sram_ce_n`=0 and `sram_oe_n`=0 for exactly RD_CYC (14) cycles on a stable address. Then `rd_latch` is 1 for exactly one cycle, 18 clocks after the edge, and `rd_data` holds the SRAM data sampled at the end of the window.
- R8: When a write and a read are pending together, the write is served to completion first, and then the read is served.
- R9: `sram_we_n` and `sram_oe_n` are never 0 together, and `sram_we_n`=0 only occurs with `sram_ce_n`=0.
- R10: When a write strobe and a counter edge arrive together, both accesses finish, and `rd_latch` pulses, within 40 system clocks (200 ns at 200 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb_a | input | 1 | Asynchronous write strobe; rising edge requests a write |
| wr_addr | input | 21 | Write address, held by the writer around its strobe |
| cnt_clk_a | input | 1 | Asynchronous counter clock; rising edge steps the counter and requests a read |
| cnt_load | input | 1 | Selects load instead of increment on the next counter edge |
| cnt_preload | input | 21 | Value loaded into the counter |
| rd_offset | input | 21 | Offset added to the counter to form the read address |
| sram_rdata | input | 8 | Data returned by the SRAM |
| sram_addr | output | 21 | Shared SRAM address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| wr_bus_en | output | 1 | Enables the writer's data buffer onto the SRAM bus |
| rd_data | output | 8 | Read holding register |
| rd_latch | output | 1 | One-cycle pulse when `rd_data` is fresh |

## Verification
The bench raises each asynchronous input just after a falling clock edge. It then numbers the falling edges that follow, so every result has a fixed due position. Write-enable first goes low at edge 5. Output-enable goes low at edge 4 for a read alone, or at edge 11 when a write runs first. The latch pulse is due at edge 18, or at edge 25 when a write runs first. A monitor samples only on falling edges, where all registered outputs are settled. It measures the length of each enable window and the address stability inside it. The bench reads those measurements only after a fixed idle stretch following each operation, so no check depends on the order of processes at a clock edge.

// File: rtl/sram_arb_pkg.sv
`timescale 1ns/1ps
package sram_arb_pkg;

    localparam int ADDR_W = 21;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WHOLD  = 3'd3,
        ST_RACC   = 3'd4
    } seq_st_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic bus_en;
    } mem_ctl_t;

    localparam mem_ctl_t CTL_OFF = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, bus_en: 1'b0};

    // Pin levels for each sequencer state
    function automatic mem_ctl_t ctl_of(seq_st_e s);
        mem_ctl_t c;
        c = CTL_OFF;
        unique case (s)
            ST_WSETUP, ST_WHOLD: begin
                c.ce_n   = 1'b0;
                c.bus_en = 1'b1;
            end
            ST_WPULSE: begin
                c.ce_n   = 1'b0;
                c.we_n   = 1'b0;
                c.bus_en = 1'b1;
            end
            ST_RACC: begin
                c.ce_n = 1'b0;
                c.oe_n = 1'b0;
            end
            default: c = CTL_OFF;
        endcase
        return c;
    endfunction

    // Address sum that wraps at the address width
    function automatic addr_t addr_add(addr_t a, addr_t b);
        return a + b;
    endfunction

endpackage

// File: rtl/arb_edge_sync.sv
`timescale 1ns/1ps
module arb_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_a,
    output logic rise
);
    // chain[STAGES-1:0] synchronize, chain[STAGES] is the previous settled level
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], in_a};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);  // R2

endmodule

// File: rtl/arb_read_counter.sv
`timescale 1ns/1ps
module arb_read_counter
    import sram_arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  logic  load,
    input  addr_t preload,
    input  addr_t offset,
    output addr_t rd_addr
);
    addr_t count_q;

    always_ff @(posedge clk) begin
        if (rst)       count_q <= '0;
        else if (step) count_q <= load ? preload : addr_add(count_q, addr_t'(1));
    end

    assign rd_addr = addr_add(count_q, offset);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (count_q == addr_t'($past(count_q) + 1'b1)));  // R4
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (step && load) |=> (count_q == $past(preload)));  // R5
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(count_q));  // R4

endmodule

// File: rtl/arb_access_seq.sv
`timescale 1ns/1ps
module arb_access_seq
    import sram_arb_pkg::*;
#(
    parameter int WE_CYC = 4,
    parameter int RD_CYC = 14
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_req,
    input  addr_t    wr_addr,
    input  logic     rd_req,
    input  addr_t    rd_addr,
    input  data_t    mem_rdata,
    output addr_t    mem_addr,
    output mem_ctl_t mem_ctl,
    output data_t    rd_data,
    output logic     rd_latch
);
    localparam int TMR_MAX = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int RUN_W   = TMR_W + 1;

    seq_st_e     st_q, st_d;
    logic [TMR_W-1:0] tmr_q;
    logic        wr_pend_q, rd_pend_q;
    logic        take_wr, take_rd, rd_done;
    addr_t       wr_addr_q, addr_q;
    mem_ctl_t    ctl_q;
    data_t       rd_data_q;
    logic        rd_latch_q;

    always_comb begin
        st_d    = st_q;
        take_wr = 1'b0;
        take_rd = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (wr_pend_q) begin
                    st_d    = ST_WSETUP;
                    take_wr = 1'b1;
                end else if (rd_pend_q) begin
                    st_d    = ST_RACC;
                    take_rd = 1'b1;
                end
            end
            ST_WSETUP: st_d = ST_WPULSE;
            ST_WPULSE: if (tmr_q == TMR_W'(WE_CYC - 1)) st_d = ST_WHOLD;
            ST_WHOLD:  st_d = ST_IDLE;
            ST_RACC:   if (tmr_q == TMR_W'(RD_CYC - 1)) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    assign rd_done = (st_q == ST_RACC) && (st_d == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            tmr_q      <= '0;
            wr_pend_q  <= 1'b0;
            rd_pend_q  <= 1'b0;
            wr_addr_q  <= '0;
            addr_q     <= '0;
            ctl_q      <= CTL_OFF;
            rd_data_q  <= '0;
            rd_latch_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            tmr_q <= (st_d != st_q) ? '0 : tmr_q + TMR_W'(1);
            ctl_q <= ctl_of(st_d);

            if (wr_req)       wr_pend_q <= 1'b1;
            else if (take_wr) wr_pend_q <= 1'b0;
            if (rd_req)       rd_pend_q <= 1'b1;
            else if (take_rd) rd_pend_q <= 1'b0;

            if (wr_req)       wr_addr_q <= wr_addr;
            if (take_wr)      addr_q    <= wr_addr_q;
            else if (take_rd) addr_q    <= rd_addr;

            rd_latch_q <= rd_done;
            if (rd_done) rd_data_q <= mem_rdata;
        end
    end

    assign mem_addr = addr_q;
    assign mem_ctl  = ctl_q;
    assign rd_data  = rd_data_q;
    assign rd_latch = rd_latch_q;

    // Run-length counters of the enable pins, used by the window checks below
    logic [RUN_W-1:0] we_run, oe_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            we_run <= '0;
            oe_run <= '0;
        end else begin
            if (ctl_q.we_n)        we_run <= '0;
            else if (we_run != '1) we_run <= we_run + RUN_W'(1);
            if (ctl_q.oe_n)        oe_run <= '0;
            else if (oe_run != '1) oe_run <= oe_run + RUN_W'(1);
        end
    end

    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.we_n) |-> (we_run >= RUN_W'(WE_CYC)));  // R3
    AST_WE_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl_q.we_n) |-> (addr_q == $past(addr_q)));  // R3
    AST_READ_WINDOW: assert property (@(posedge clk) disable iff (rst)
        rd_latch_q |-> (oe_run >= RUN_W'(RD_CYC)));  // R7
    AST_LATCH_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_latch_q |=> !rd_latch_q);  // R7
    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && wr_pend_q && rd_pend_q) |=> (st_q == ST_WSETUP));  // R8
    AST_NO_WE_OE: assert property (@(posedge clk) disable iff (rst)
        !(!ctl_q.we_n && !ctl_q.oe_n));  // R9
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.we_n |-> !ctl_q.ce_n);  // R9

endmodule

// File: rtl/sram_share_arb.sv
`timescale 1ns/1ps
module sram_share_arb
    import sram_arb_pkg::*;
#(
    parameter int WE_CYC      = 4,
    parameter int RD_CYC      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb_a,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              cnt_clk_a,
    input  logic              cnt_load,
    input  logic [ADDR_W-1:0] cnt_preload,
    input  logic [ADDR_W-1:0] rd_offset,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic              wr_bus_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_latch
);
    logic     wr_rise, cnt_rise;
    addr_t    rd_addr;
    mem_ctl_t ctl;

    arb_edge_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk  (clk),
        .rst  (rst),
        .in_a (wr_stb_a),
        .rise (wr_rise)
    );

    arb_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk  (clk),
        .rst  (rst),
        .in_a (cnt_clk_a),
        .rise (cnt_rise)
    );

    arb_read_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step    (cnt_rise),
        .load    (cnt_load),
        .preload (cnt_preload),
        .offset  (rd_offset),
        .rd_addr (rd_addr)
    );

    arb_access_seq #(.WE_CYC(WE_CYC), .RD_CYC(RD_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wr_rise),
        .wr_addr   (wr_addr),
        .rd_req    (cnt_rise),
        .rd_addr   (rd_addr),
        .mem_rdata (sram_rdata),
        .mem_addr  (sram_addr),
        .mem_ctl   (ctl),
        .rd_data   (rd_data),
        .rd_latch  (rd_latch)
    );

    assign sram_ce_n = ctl.ce_n;
    assign sram_we_n = ctl.we_n;
    assign sram_oe_n = ctl.oe_n;
    assign wr_bus_en = ctl.bus_en;

endmodule

// File: tb/sram_share_arb_tb.sv
`timescale 1ns/1ps
module sram_share_arb_tb;

    typedef struct packed {
        logic        ld;
        logic [20:0] pre;
        logic [20:0] off;
        logic [20:0] exp;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 21'h000000, 21'h000000, 21'h000001},
        '{1'b0, 21'h000000, 21'h000010, 21'h000012},
        '{1'b1, 21'h1FFFFE, 21'h000000, 21'h1FFFFE},
        '{1'b0, 21'h000000, 21'h000000, 21'h1FFFFF},
        '{1'b0, 21'h000000, 21'h000000, 21'h000000},
        '{1'b0, 21'h000000, 21'h1FFFFF, 21'h000000},
        '{1'b1, 21'h0ABCDE, 21'h000100, 21'h0ABDDE},
        '{1'b0, 21'h000000, 21'h100000, 21'h1ABCDF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb_a = 1'b0;
    logic [20:0] wr_addr = '0;
    logic        cnt_clk_a = 1'b0;
    logic        cnt_load = 1'b0;
    logic [20:0] cnt_preload = '0;
    logic [20:0] rd_offset = '0;
    logic [7:0]  sram_rdata;
    logic [20:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, wr_bus_en, rd_latch;
    logic [7:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(logic [20:0] a);
        return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
    endfunction

    assign sram_rdata = pat(sram_addr);

    sram_share_arb u_dut (
        .clk         (clk),
        .rst         (rst),
        .wr_stb_a    (wr_stb_a),
        .wr_addr     (wr_addr),
        .cnt_clk_a   (cnt_clk_a),
        .cnt_load    (cnt_load),
        .cnt_preload (cnt_preload),
        .rd_offset   (rd_offset),
        .sram_rdata  (sram_rdata),
        .sram_addr   (sram_addr),
        .sram_ce_n   (sram_ce_n),
        .sram_we_n   (sram_we_n),
        .sram_oe_n   (sram_oe_n),
        .wr_bus_en   (wr_bus_en),
        .rd_data     (rd_data),
        .rd_latch    (rd_latch)
    );

    // Falling-edge monitor of the SRAM pins
    int          we_run = 0, oe_run = 0, last_we_run = 0, last_oe_run = 0;
    logic [20:0] we_addr = '0, oe_addr = '0;
    bit          we_moved, we_bus_bad, we_setup_ok, we_hold_ok;
    bit          oe_moved, oe_ce_bad, overlap;
    logic        prev_ce_n = 1'b1, prev_we_n = 1'b1;
    logic [20:0] prev_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!sram_we_n && !sram_oe_n) overlap = 1'b1;
            if (!sram_we_n) begin
                if (we_run == 0) begin
                    we_addr     = sram_addr;
                    we_moved    = 1'b0;
                    we_bus_bad  = 1'b0;
                    we_setup_ok = !prev_ce_n && prev_we_n && (prev_addr == sram_addr);
                end else if (sram_addr != we_addr) we_moved = 1'b1;
                if (!wr_bus_en || sram_ce_n) we_bus_bad = 1'b1;
                we_run++;
            end else if (we_run != 0) begin
                last_we_run = we_run;
                we_run      = 0;
                we_hold_ok  = !sram_ce_n && (sram_addr == we_addr);
            end
            if (!sram_oe_n) begin
                if (oe_run == 0) begin
                    oe_addr   = sram_addr;
                    oe_moved  = 1'b0;
                    oe_ce_bad = 1'b0;
                end else if (sram_addr != oe_addr) oe_moved = 1'b1;
                if (sram_ce_n) oe_ce_bad = 1'b1;
                oe_run++;
            end else if (oe_run != 0) begin
                last_oe_run = oe_run;
                oe_run      = 0;
            end
            prev_ce_n = sram_ce_n;
            prev_we_n = sram_we_n;
            prev_addr = sram_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    // One operation: optional write strobe and/or counter edge raised together
    int op_lat, op_we_first, op_oe_first, op_latch_cnt;
    task automatic run_op(input bit do_wr, input logic [20:0] waddr, input bit do_rd,
                          input bit ld, input logic [20:0] pre, input logic [20:0] off);
        op_lat = 0; op_we_first = 0; op_oe_first = 0; op_latch_cnt = 0;
        @(negedge clk);
        cnt_load    = ld;
        cnt_preload = pre;
        rd_offset   = off;
        if (do_wr) begin
            wr_addr  = waddr;
            wr_stb_a = 1'b1;
        end
        if (do_rd) cnt_clk_a = 1'b1;
        for (int n = 1; n <= 45; n++) begin
            @(negedge clk);
            if (n == 3) wr_addr = ~waddr;
            if (n == 4) begin
                wr_stb_a  = 1'b0;
                cnt_clk_a = 1'b0;
            end
            if (!sram_we_n && op_we_first == 0) op_we_first = n;
            if (!sram_oe_n && op_oe_first == 0) op_oe_first = n;
            if (rd_latch) begin
                if (op_lat == 0) op_lat = n;
                op_latch_cnt++;
            end
        end
        cnt_load = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        string tag;
        repeat (4) @(negedge clk);
        // R1: reset values at the pins
        chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 ctl", {29'b0, sram_ce_n, sram_we_n, sram_oe_n}, 32'h7);
        chk(!wr_bus_en && !rd_latch, "R1 strobes", {30'b0, wr_bus_en, rd_latch}, 32'h0);
        chk(rd_data == 8'h00 && sram_addr == 21'h0, "R1 data/addr", {3'b0, sram_addr, rd_data}, 32'h0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // Vector table: counter steps, preloads and offsets
        for (int i = 0; i < NVEC; i++) begin
            run_op(1'b0, '0, 1'b1, VECS[i].ld, VECS[i].pre, VECS[i].off);
            tag = VECS[i].ld ? "R5" : ((VECS[i].off != 0) ? "R6" : "R4");
            chk(oe_addr == VECS[i].exp, tag, {11'b0, oe_addr}, {11'b0, VECS[i].exp});
            chk(rd_data == pat(VECS[i].exp), tag, {24'b0, rd_data}, {24'b0, pat(VECS[i].exp)});
            chk(op_lat == 18, "R7 latch due", op_lat, 18);
            chk(op_oe_first == 4, "R7 oe start", op_oe_first, 4);
            chk(op_latch_cnt == 1, "R7 one-cycle latch", op_latch_cnt, 1);
            chk(last_oe_run == 14 && !oe_moved && !oe_ce_bad, "R7 window",
                {last_oe_run[15:0], 14'b0, oe_moved, oe_ce_bad}, {16'd14, 16'h0});
        end

        // Directed writes: captured address, enable shape
        for (int w = 0; w < 2; w++) begin
            logic [20:0] wa;
            wa = (w == 0) ? 21'h155AA3 : 21'h1FFFFF;
            run_op(1'b1, wa, 1'b0, 1'b0, '0, '0);
            chk(we_addr == wa, "R2 captured addr", {11'b0, we_addr}, {11'b0, wa});
            chk(op_we_first == 5, "R3 we start", op_we_first, 5);
            chk(last_we_run == 4, "R3 we width", last_we_run, 4);
            chk(we_setup_ok && we_hold_ok, "R3 setup/hold", {30'b0, we_setup_ok, we_hold_ok}, 32'h3);
            chk(!we_moved && !we_bus_bad, "R3 addr/bus in pulse", {30'b0, we_moved, we_bus_bad}, 32'h0);
            chk(op_oe_first == 0 && op_latch_cnt == 0, "R2 no read", op_latch_cnt, 0);
        end

        // Write and read together: count now 0x1ABCDF-0x100000 = 0x0ABCDF, next 0x0ABCE0
        run_op(1'b1, 21'h02468A, 1'b1, 1'b0, '0, 21'h000020);
        chk(op_we_first != 0 && op_we_first < op_oe_first, "R8 order", op_we_first, op_oe_first);
        chk(op_oe_first == 11, "R8 read after write", op_oe_first, 11);
        chk(op_lat != 0 && op_lat <= 40, "R10 both within 200ns", op_lat, 40);
        chk(we_addr == 21'h02468A, "R8 write addr", {11'b0, we_addr}, 32'h02468A);
        chk(oe_addr == 21'h0ABD00, "R8 read addr", {11'b0, oe_addr}, 32'h0ABD00);
        chk(rd_data == pat(21'h0ABD00), "R8 read data", {24'b0, rd_data}, {24'b0, pat(21'h0ABD00)});
        chk(!overlap, "R9 we/oe overlap", {31'b0, overlap}, 32'h0);

        // Reset again mid-run: counter returns to zero
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(rd_data == 8'h00 && !rd_latch && sram_oe_n, "R1 re-reset", {24'b0, rd_data}, 32'h0);
        run_op(1'b0, '0, 1'b1, 1'b0, '0, '0);
        chk(oe_addr == 21'h000001, "R1 count cleared", {11'b0, oe_addr}, 32'h1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule